// File: doc/BRIEF.md
# Block Carry-Skip Adder

A purely combinational binary adder that adds two N-bit operands and a carry-in, and returns an N-bit sum with a carry-out. The operand bits are cut into consecutive blocks. Inside each block the carry ripples bit by bit. Each block also computes a block-propagate flag, the AND of its per-bit propagate terms. When that flag is set, a 2-to-1 multiplexer hands the block's incoming carry directly to the next block, so the carry does not wait on the ripple chain.

The partition is a parameter. Block widths may all be equal, giving a fixed partition such as four 4-bit blocks for 16 bits. They may also differ, giving a variable partition such as narrow blocks at both ends and wide blocks in the middle. An optional second level gathers a parameterised number of adjacent blocks into a group. A second multiplexer then lets a carry jump over the whole group when every bit inside the group propagates. Whatever partition and grouping are chosen, the result is the exact arithmetic sum.

Top module: `csk_adder`

## Requirements
- R1: For every operand pair and carry-in, {c_o, sum_o} equals the arithmetic value a_i + b_i + c_i, for every legal partition and grouping.
- R2: Each bit forms propagate as a XOR b and generate as a AND b. Its sum bit is propagate XOR the carry entering that bit, and its carry out is generate OR (propagate AND incoming carry).
- R3: When every bit pair propagates (a_i XOR b_i all ones), c_o equals c_i. sum_o is then all ones for c_i = 0 and all zeros for c_i = 1.
- R4: When every bit pair generates (a_i and b_i both all ones), c_o is 1 and sum_o is all ones except bit 0, which equals c_i.
- R5: When every bit pair kills (a_i and b_i both zero), c_o is 0 and sum_o is zero except bit 0, which equals c_i.
- R6: Block widths come from parameter BLK_W, one 8-bit field per block, with block 0 (the least significant) in bits [7:0] and block k in bits [8k+7:8k]. NBLK gives the number of blocks. Elaboration stops with an error if the first NBLK widths do not sum to N or if any of them is zero.
- R7: A variable partition (for example 2-3-4-4-3-2 on 18 bits) gives results identical to the arithmetic sum, including carries that cross every block boundary.
- R8: With GRP_SZ > 0, blocks are grouped GRP_SZ at a time from block 0 upward. A group's carry-out equals the carry entering the group whenever every bit in the group propagates. GRP_SZ = 0 removes the second level.
- R9: The block has no clock or reset. Outputs depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| c_o | output | 1 | Carry out of the most significant bit |

## Verification
The checks take for granted that the inputs carry known 0/1 values. While any input bit is still unknown, for example before the bench first drives the operands, no check is made. The bench drives every input from a defined value from time zero. It changes the inputs only between sampling points, so each check sees operands that have settled through the full ripple and skip network. The stimulus covers every operand pair of a small 4-bit, three-block, grouped instance. It also covers a vector table, random operands, and whole-word propagate, generate and kill patterns on the fixed 16-bit and variable 18-bit partitions.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Bits per block-width field in the partition vector.
    localparam int unsigned WF   = 8;
    // Largest number of blocks the partition vector can describe.
    localparam int unsigned MAXB = 16;

    typedef logic [MAXB*WF-1:0] widths_t;

    // Width of block idx.
    function automatic int unsigned blk_w(widths_t w, int unsigned idx);
        return int'(w[idx*WF +: WF]);
    endfunction

    // Position of the least significant bit of block idx.
    function automatic int unsigned blk_lo(widths_t w, int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < idx; j++) begin
            acc += blk_w(w, j);
        end
        return acc;
    endfunction

    // Total width covered by the first n blocks.
    function automatic int unsigned sum_w(widths_t w, int unsigned n);
        return blk_lo(w, n);
    endfunction

    // Number of zero-width entries among the first n blocks.
    function automatic int unsigned zero_cnt(widths_t w, int unsigned n);
        int unsigned z;
        z = 0;
        for (int unsigned j = 0; j < n; j++) begin
            if (blk_w(w, j) == 0) z++;
        end
        return z;
    endfunction

endpackage

// File: rtl/csk_fa_cell.sv
module csk_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o,
    output logic p_o
);

    logic gen;

    always_comb begin
        p_o = a_i ^ b_i;
        gen = a_i & b_i;
        s_o = p_o ^ c_i;
        c_o = gen | (p_o & c_i);
    end

endmodule

// File: rtl/csk_block.sv
module csk_block #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         gp_o
);

    // rip[k] is the carry entering bit k; rip[W] leaves the top bit.
    logic [W:0]   rip;
    logic [W-1:0] prop;

    assign rip[0] = c_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        csk_fa_cell u_fa (
            .a_i (a_i[k]),
            .b_i (b_i[k]),
            .c_i (rip[k]),
            .s_o (sum_o[k]),
            .c_o (rip[k+1]),
            .p_o (prop[k])
        );
    end

    // Block propagate selects between the incoming carry and the ripple.
    always_comb begin
        gp_o = &prop;
        c_o  = gp_o ? c_i : rip[W];
    end

endmodule

// File: rtl/csk_group_skip.sv
module csk_group_skip #(
    parameter int unsigned NB = 2
) (
    input  logic [NB-1:0] gp_i,
    input  logic          c_i,
    input  logic          rip_c_i,
    output logic          c_o
);

    logic sgp;

    always_comb begin
        sgp = &gp_i;
        c_o = sgp ? c_i : rip_c_i;
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int unsigned      N      = 16,
    parameter int unsigned      NBLK   = 4,
    parameter csk_pkg::widths_t BLK_W  = csk_pkg::widths_t'({8'd4, 8'd4, 8'd4, 8'd4}),
    parameter int unsigned      GRP_SZ = 0
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c_i,
    output logic [N-1:0] sum_o,
    output logic         c_o
);

    // Blocks per group; with the second level off, all blocks form one
    // group whose carry simply follows the last block's skip mux.
    localparam int unsigned EFF  = (GRP_SZ == 0) ? NBLK : GRP_SZ;
    localparam int unsigned NGRP = (NBLK + EFF - 1) / EFF;

    if (csk_pkg::sum_w(BLK_W, NBLK) != N) begin : g_bad_total
        $error("csk_adder: block widths do not add up to N");
    end
    if (csk_pkg::zero_cnt(BLK_W, NBLK) != 0) begin : g_bad_zero
        $error("csk_adder: a block width is zero");
    end
    if (NBLK > csk_pkg::MAXB) begin : g_bad_count
        $error("csk_adder: too many blocks");
    end

    logic [NBLK-1:0] blk_ci;
    logic [NBLK-1:0] blk_co;
    logic [NBLK-1:0] blk_gp;
    logic [NGRP:0]   grp_c;

    assign grp_c[0] = c_i;

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        localparam int unsigned LO = csk_pkg::blk_lo(BLK_W, i);
        localparam int unsigned W  = csk_pkg::blk_w(BLK_W, i);

        if (i % EFF == 0) begin : g_head
            assign blk_ci[i] = grp_c[i/EFF];
        end else begin : g_chain
            assign blk_ci[i] = blk_co[i-1];
        end

        csk_block #(.W(W)) u_blk (
            .a_i   (a_i[LO +: W]),
            .b_i   (b_i[LO +: W]),
            .c_i   (blk_ci[i]),
            .sum_o (sum_o[LO +: W]),
            .c_o   (blk_co[i]),
            .gp_o  (blk_gp[i])
        );
    end

    if (GRP_SZ == 0) begin : g_one_level
        logic gp_unused;
        assign gp_unused = &blk_gp;
        assign grp_c[1]  = blk_co[NBLK-1];
    end else begin : g_two_level
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int unsigned FIRST = g * EFF;
            localparam int unsigned LAST  =
                ((FIRST + EFF) < NBLK) ? (FIRST + EFF - 1) : (NBLK - 1);
            localparam int unsigned NB    = LAST - FIRST + 1;

            csk_group_skip #(.NB(NB)) u_grp (
                .gp_i    (blk_gp[LAST:FIRST]),
                .c_i     (grp_c[g]),
                .rip_c_i (blk_co[LAST]),
                .c_o     (grp_c[g+1])
            );
        end
    end

    assign c_o = grp_c[NGRP];

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int unsigned N = 16
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         c_i,
    input logic [N-1:0] sum_o,
    input logic         c_o
);

    logic [N:0]   ref_sum;
    logic [N-1:0] ones;
    logic [N-1:0] low_c;

    always_comb begin
        ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i};
        ones    = '1;
        low_c   = {{(N-1){1'b0}}, c_i};
        if (!$isunknown({a_i, b_i, c_i, sum_o, c_o})) begin
            // R1
            a_r1_exact_sum: assert ({c_o, sum_o} == ref_sum)
                else $error("R1: adder result differs from arithmetic sum");
            // R3
            if ((a_i ^ b_i) == ones) begin
                a_r3_all_prop: assert (c_o == c_i && sum_o == (c_i ? '0 : ones))
                    else $error("R3: all-propagate case wrong");
            end
            // R4
            if ((a_i & b_i) == ones) begin
                a_r4_all_gen: assert (c_o && sum_o == {ones[N-1:1], c_i})
                    else $error("R4: all-generate case wrong");
            end
            // R5
            if ((a_i | b_i) == '0) begin
                a_r5_all_kill: assert (!c_o && sum_o == low_c)
                    else $error("R5: all-kill case wrong");
            end
        end
    end

endmodule

bind csk_adder csk_adder_chk #(.N(N)) u_chk (.*);

// File: tb/csk_adder_tb.sv
module csk_adder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 16-bit fixed partition, single level (u_dut) and grouped (u_fix2)
    logic [15:0] a16 = '0, b16 = '0;
    logic        c16 = 1'b0;
    logic [15:0] s_fix, s_fix2;
    logic        co_fix, co_fix2;

    // 18-bit variable partition 2-3-4-4-3-2 with groups of two
    logic [17:0] a18 = '0, b18 = '0;
    logic        c18 = 1'b0;
    logic [17:0] s18;
    logic        co18;

    // 4-bit partition 1-2-1 with groups of two
    logic [3:0]  a4 = '0, b4 = '0;
    logic        c4 = 1'b0;
    logic [3:0]  s4;
    logic        co4;

    csk_adder #(.N(16), .NBLK(4),
                .BLK_W(csk_pkg::widths_t'({8'd4, 8'd4, 8'd4, 8'd4})), .GRP_SZ(0))
        u_dut (.a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s_fix), .c_o(co_fix));

    csk_adder #(.N(16), .NBLK(4),
                .BLK_W(csk_pkg::widths_t'({8'd4, 8'd4, 8'd4, 8'd4})), .GRP_SZ(2))
        u_fix2 (.a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s_fix2), .c_o(co_fix2));

    csk_adder #(.N(18), .NBLK(6),
                .BLK_W(csk_pkg::widths_t'({8'd2, 8'd3, 8'd4, 8'd4, 8'd3, 8'd2})), .GRP_SZ(2))
        u_var (.a_i(a18), .b_i(b18), .c_i(c18), .sum_o(s18), .c_o(co18));

    csk_adder #(.N(4), .NBLK(3),
                .BLK_W(csk_pkg::widths_t'({8'd1, 8'd2, 8'd1})), .GRP_SZ(2))
        u_small (.a_i(a4), .b_i(b4), .c_i(c4), .sum_o(s4), .c_o(co4));

    // {a, b, carry-in, expected {carry-out, sum}}
    localparam logic [49:0] VEC [13] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h0_0000},
        {16'hFFFF, 16'h0000, 1'b1, 17'h1_0000},
        {16'hFFFF, 16'h0000, 1'b0, 17'h0_FFFF},
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1_FFFE},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF},
        {16'h0F0F, 16'hF0F0, 1'b1, 17'h1_0000},
        {16'h1234, 16'h4321, 1'b0, 17'h0_5555},
        {16'h8000, 16'h8000, 1'b0, 17'h1_0000},
        {16'h00FF, 16'h0001, 1'b0, 17'h0_0100},
        {16'h0FFF, 16'h0001, 1'b0, 17'h0_1000},
        {16'h7FFF, 16'h0001, 1'b0, 17'h0_8000},
        {16'hAAAA, 16'h5555, 1'b1, 17'h1_0000},
        {16'h000F, 16'h00F1, 1'b0, 17'h0_0100}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(posedge clk);
        a16 = a; b16 = b; c16 = c;
        @(negedge clk);
    endtask

    task automatic drive18(input logic [17:0] a, input logic [17:0] b, input logic c);
        @(posedge clk);
        a18 = a; b18 = b; c18 = c;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [16:0] exp17;
        logic [18:0] exp19;
        logic [17:0] r18;
        logic [15:0] r16;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: after reset with zero inputs, outputs are zero
        check("R9 reset u_dut", {15'd0, co_fix, s_fix}, 32'd0);
        check("R9 reset u_var", {13'd0, co18, s18}, 32'd0);

        // R1 / R2: table of vectors on both 16-bit instances
        for (int i = 0; i < 13; i++) begin
            drive16(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
            check("R1 table fixed", {15'd0, co_fix, s_fix}, {15'd0, VEC[i][16:0]});
            check("R2 table grouped", {15'd0, co_fix2, s_fix2}, {15'd0, VEC[i][16:0]});
        end

        // R1: exhaustive on the 4-bit, three-block, grouped instance
        for (int v = 0; v < 512; v++) begin
            @(posedge clk);
            {a4, b4, c4} = v[8:0];
            @(negedge clk);
            check("R1 exhaustive 4-bit", {27'd0, co4, s4},
                  32'(a4) + 32'(b4) + 32'(c4));
        end

        // R1 / R7 / R8: random operands
        for (int i = 0; i < 1500; i++) begin
            drive16(16'($urandom), 16'($urandom), 1'($urandom));
            exp17 = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
            check("R1 random fixed", {15'd0, co_fix, s_fix}, {15'd0, exp17});
            check("R8 random grouped", {15'd0, co_fix2, s_fix2}, {15'd0, exp17});
            drive18(18'($urandom), 18'($urandom), 1'($urandom));
            exp19 = {1'b0, a18} + {1'b0, b18} + {18'd0, c18};
            check("R7 random variable", {13'd0, co18, s18}, {13'd0, exp19});
        end

        // R3: all-propagate with varied patterns, both carry-in values
        for (int i = 0; i < 8; i++) begin
            r16 = 16'($urandom);
            r18 = 18'($urandom);
            for (int c = 0; c < 2; c++) begin
                drive16(r16, ~r16, 1'(c));
                check("R3 all-propagate fixed", {15'd0, co_fix, s_fix},
                      {15'd0, 1'(c), (c != 0) ? 16'h0000 : 16'hFFFF});
                check("R3 all-propagate grouped", {15'd0, co_fix2, s_fix2},
                      {15'd0, 1'(c), (c != 0) ? 16'h0000 : 16'hFFFF});
                drive18(r18, ~r18, 1'(c));
                check("R3 all-propagate variable", {13'd0, co18, s18},
                      {13'd0, 1'(c), (c != 0) ? 18'h00000 : 18'h3FFFF});
            end
        end

        // R4 / R5: all-generate and all-kill, both carry-in values
        for (int c = 0; c < 2; c++) begin
            drive16(16'hFFFF, 16'hFFFF, 1'(c));
            check("R4 all-generate fixed", {15'd0, co_fix, s_fix},
                  {15'd0, 1'b1, 15'h7FFF, 1'(c)});
            drive18(18'h3FFFF, 18'h3FFFF, 1'(c));
            check("R4 all-generate variable", {13'd0, co18, s18},
                  {13'd0, 1'b1, 17'h1FFFF, 1'(c)});
            drive16(16'h0000, 16'h0000, 1'(c));
            check("R5 all-kill fixed", {15'd0, co_fix2, s_fix2},
                  {15'd0, 1'b0, 15'd0, 1'(c)});
            drive18(18'h00000, 18'h00000, 1'(c));
            check("R5 all-kill variable", {13'd0, co18, s18},
                  {13'd0, 1'b0, 17'd0, 1'(c)});
        end

        // R8: carry crosses the first group (bits 0..4) by the group skip
        drive18(18'h0001F, 18'h00000, 1'b1);
        check("R8 group skip into bit 5", {13'd0, co18, s18}, 32'h00020);
        drive18(18'h0001F, 18'h00020, 1'b1);
        check("R8 group skip past bit 5", {13'd0, co18, s18}, 32'h00040);
        // R6 / R7: carry generated in the last narrow block
        drive18(18'h20000, 18'h20000, 1'b0);
        check("R6 top block carry", {13'd0, co18, s18}, 32'h40000);
        drive18(18'h00001, 18'h3FFFF, 1'b0);
        check("R7 carry through all blocks", {13'd0, co18, s18}, 32'h40000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule